// File: doc/BRIEF.md
# Two-Level Wake Status Unit

This unit records activity on a small set of general-purpose wake pins and reports it through two levels of status. Each pin passes through a two-stage synchronizer and an edge detector that sees both rising and falling transitions. An edge counts only when that pin is set up as an input and its interrupt enable is on. A qualified edge sets a sticky bit in the second-level status register. A single bit in a top-level status register, bit 0, shows whether any second-level bit is pending.

Software reads the second-level status at one of two addresses. The mirror address returns the bits and changes nothing. The primary address returns the same bits, and a strobed read there clears the second level. Because the top-level bit follows the second level, it clears as well. If an edge arrives in the same cycle as a clearing read, that edge wins and its bit stays set, so no event is lost. The read data is combinational from the current state and the address. The clear takes effect at the next clock edge.

Top module: `wake_status_unit`

## Requirements
- R1: After reset, every read address returns 8'h00 and `top_irq_o` is 0.
- R2: A rising or a falling transition on a pin whose direction bit is 0 and whose enable bit is 1 sets status bit i (pin i maps to bit i, bits 2:0). The bit becomes visible on the third rising clock edge after the pin changes.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever it does.
- R4: A pin whose enable bit is 0 never sets its status bit. Enabling the pin later does not set the bit for edges that came before.
- R5: A read at address 1 (mirror) returns the second-level status in bits 2:0 and clears nothing, even with `rd_stb_i` high.
- R6: A read at address 2 (primary) returns the same value as the mirror. When `rd_stb_i` is high, the read clears the second-level bits and the top-level bit from the next clock edge on.
- R7: A read at address 0 returns the top-level register. Bit 0 is the OR of all second-level bits, bits 7:1 read 0, and `top_irq_o` equals bit 0.
- R8: If a qualified edge sets a bit in the same cycle as a clearing primary read, that bit is set after the clock edge. The top-level bit is then also 1.
- R9: Bits 7:3 of the second-level status always read 0, and address 3 reads 8'h00.
- R10: A set status bit stays set, whatever the pins do, until a clearing primary read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 3 | Wake pins, asynchronous to clk |
| pin_dir_i | input | 3 | Per-pin direction, 1 = output (pin ignored) |
| pin_irq_en_i | input | 3 | Per-pin interrupt enable, 1 = enabled |
| rd_stb_i | input | 1 | Read strobe; with address 2 it clears the status |
| rd_addr_i | input | 2 | 0 top level, 1 mirror, 2 primary (clearing), 3 unused |
| rd_data_o | output | 8 | Read data for the current address |
| top_irq_o | output | 1 | Top-level status bit 0 |

## Verification
The hardest case to reach is an edge that lands in the same cycle as a clearing primary read. The strobe has to line up with the synchronizer latency, so it must be raised exactly two clock edges after the pin changes. The bench sets this up directly by toggling a pin, stepping two cycles and then strobing the primary address. A long pseudo-random phase then drives pins, directions, enables, addresses and strobes, and a queue-based reference model checks every clock. That phase also produces many other coincidences of edges and clears, and on masked pins.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  typedef enum logic [1:0] {
    RD_TOP     = 2'd0,
    RD_MIRROR  = 2'd1,
    RD_PRIMARY = 2'd2,
    RD_NONE    = 2'd3
  } rd_addr_e;
endpackage

// File: rtl/wsu_rst_sync.sv
module wsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/wsu_edge_detect.sv
module wsu_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic edge_o
);
  logic sync1_q;
  logic sync2_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  assign edge_o = sync2_q ^ last_q;

  // R2: an edge pulse never lasts beyond one cycle while the pin is still
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(sync1_q) && (sync1_q == sync2_q)) |=> !edge_o);
endmodule

// File: rtl/wsu_level2_status.sv
module wsu_level2_status #(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic                clr_i,
  output logic [NUM_PINS-1:0] stat_d,
  output logic [NUM_PINS-1:0] stat_q
);
  logic [NUM_PINS-1:0] base;

  always_comb begin
    base   = clr_i ? '0 : stat_q;
    stat_d = base | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R10: without a clear no pending bit is ever dropped
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6: a clear with no new edge leaves the register empty
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (set_i == '0)) |=> (stat_q == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_hold
    // R8: an edge coinciding with a clear survives
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i[i]) |=> stat_q[i]);
  end
endmodule

// File: rtl/wsu_top_status.sv
module wsu_top_status #(
  parameter int NUM_PINS = 3,
  parameter int REG_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl2_d,
  input  logic [NUM_PINS-1:0] lvl2_q,
  input  logic [1:0]          rd_addr_i,
  output logic                top_q,
  output logic [REG_W-1:0]    rd_data_o
);
  import wsu_pkg::*;

  logic top_d;

  always_comb top_d = |lvl2_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= 1'b0;
    else        top_q <= top_d;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RD_TOP:     rd_data_o[0] = top_q;
      RD_MIRROR:  rd_data_o[NUM_PINS-1:0] = lvl2_q;
      RD_PRIMARY: rd_data_o[NUM_PINS-1:0] = lvl2_q;
      default:    rd_data_o = '0;
    endcase
  end

  // R7: the top-level register tracks the OR of the second level
  assert_top_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
    top_q == (|lvl2_q));

  // R9: reserved bits never read as one
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[REG_W-1:NUM_PINS] == '0);
endmodule

// File: rtl/wake_status_unit.sv
module wake_status_unit #(
  parameter int NUM_PINS = 3,
  parameter int REG_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_dir_i,
  input  logic [NUM_PINS-1:0] pin_irq_en_i,
  input  logic                rd_stb_i,
  input  logic [1:0]          rd_addr_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic                top_irq_o
);
  import wsu_pkg::*;

  logic                rst_n_sync;
  logic [NUM_PINS-1:0] edges;
  logic [NUM_PINS-1:0] set_vec;
  logic                clr;
  logic [NUM_PINS-1:0] lvl2_d;
  logic [NUM_PINS-1:0] lvl2_q;
  logic                top_q;

  wsu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wsu_edge_detect u_edge (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .pin_i  (pin_i[i]),
      .edge_o (edges[i])
    );
  end

  always_comb begin
    set_vec = edges & ~pin_dir_i & pin_irq_en_i;
    clr     = rd_stb_i && (rd_addr_i == RD_PRIMARY);
  end

  wsu_level2_status #(.NUM_PINS(NUM_PINS)) u_lvl2 (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (set_vec),
    .clr_i  (clr),
    .stat_d (lvl2_d),
    .stat_q (lvl2_q)
  );

  wsu_top_status #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_top (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .lvl2_d    (lvl2_d),
    .lvl2_q    (lvl2_q),
    .rd_addr_i (rd_addr_i),
    .top_q     (top_q),
    .rd_data_o (rd_data_o)
  );

  assign top_irq_o = top_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_qual
    // R3 and R4: a bit only rises after a qualified pin configuration
    assert_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
      $rose(lvl2_q[i]) |-> $past(!pin_dir_i[i] && pin_irq_en_i[i]));
  end

  // R5: a mirror read never clears anything
  assert_mirror_keep_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rd_addr_i == RD_MIRROR) |=> ((lvl2_q & $past(lvl2_q)) == $past(lvl2_q)));
endmodule

// File: tb/wake_status_unit_test.sv
module wake_status_unit_test;
  logic       clk;
  logic       rst_n;
  logic [2:0] pin;
  logic [2:0] dir;
  logic [2:0] en;
  logic       stb;
  logic [1:0] addr;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit run_cmp = 0;
  bit done = 0;

  wake_status_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin),
    .pin_dir_i    (dir),
    .pin_irq_en_i (en),
    .rd_stb_i     (stb),
    .rd_addr_i    (addr),
    .rd_data_o    (rd_data),
    .top_irq_o    (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: pin history queue and a status integer
  int        mstat;
  logic [2:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstat = 0;
      hist = {3'b000, 3'b000, 3'b000};
    end else begin
      logic [2:0] ev;
      logic [2:0] qual;
      ev   = hist[1] ^ hist[2];
      qual = ev & ~dir & en;
      if (stb && addr == 2'd2) mstat = 0;
      mstat = mstat | int'(qual);
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && run_cmp) begin
      logic [7:0] exp;
      case (addr)
        2'd0: exp = {7'd0, mstat != 0};
        2'd1: exp = mstat[7:0];
        2'd2: exp = mstat[7:0];
        default: exp = 8'h00;
      endcase
      case (addr)
        2'd0: chk("R7 model top", rd_data, exp);
        2'd1: chk("R5 model mirror", rd_data, exp);
        2'd2: chk("R6 model primary", rd_data, exp);
        default: chk("R9 model unused", rd_data, exp);
      endcase
      chk("R7 model irq", {7'd0, irq}, {7'd0, mstat != 0});
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic clear_all();
    addr = 2'd2; stb = 1'b1;
    step(1);
    stb = 1'b0; addr = 2'd1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; pin = 3'b000; dir = 3'b000; en = 3'b111; stb = 1'b0; addr = 2'd0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    rd(2'd0, "R1 reset top", 8'h00);
    rd(2'd1, "R1 reset mirror", 8'h00);
    rd(2'd2, "R1 reset primary", 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    run_cmp = 1;

    // R2 rising edge latency
    addr = 2'd1;
    pin[0] = 1'b1;
    step(2);
    rd(2'd1, "R2 not yet after two edges", 8'h00);
    step(1);
    rd(2'd1, "R2 rising edge sets bit0", 8'h01);
    rd(2'd0, "R7 top bit set", 8'h01);
    chk("R7 irq high", {7'd0, irq}, 8'h01);

    // R5 mirror with strobe clears nothing; R10 sticky
    addr = 2'd1; stb = 1'b1;
    step(3);
    stb = 1'b0;
    rd(2'd1, "R5 mirror strobe keeps", 8'h01);
    pin[0] = 1'b0;
    step(5);
    rd(2'd1, "R10 sticky after falling", 8'h01);

    // R6 clearing primary read
    rd(2'd2, "R6 primary returns status", 8'h01);
    clear_all();
    rd(2'd1, "R6 mirror cleared", 8'h00);
    rd(2'd0, "R6 top cleared", 8'h00);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);

    // R2 falling edge on pin 2
    pin[2] = 1'b1;
    step(5);
    clear_all();
    pin[2] = 1'b0;
    step(3);
    rd(2'd1, "R2 falling edge sets bit2", 8'h04);
    clear_all();

    // R3 output-direction pin ignored
    dir[1] = 1'b1;
    pin[1] = 1'b1; step(3); pin[1] = 1'b0; step(4);
    rd(2'd1, "R3 output pin ignored", 8'h00);
    chk("R3 irq stays low", {7'd0, irq}, 8'h00);
    dir[1] = 1'b0;
    step(3);

    // R4 disabled pin ignored, no retroactive set
    en[2] = 1'b0;
    pin[2] = 1'b1; step(4);
    rd(2'd1, "R4 disabled pin ignored", 8'h00);
    en[2] = 1'b1;
    step(4);
    rd(2'd1, "R4 no retroactive set", 8'h00);

    // R8 edge coinciding with clearing read
    pin[0] = 1'b1; pin[1] = 1'b1;
    step(4);
    rd(2'd1, "R8 setup bits 0 and 1", 8'h03);
    pin[0] = 1'b0;
    step(2);
    addr = 2'd2; stb = 1'b1;
    step(1);
    stb = 1'b0;
    rd(2'd1, "R8 edge survives clear", 8'h01);
    rd(2'd0, "R8 top still set", 8'h01);

    // R9 reserved bits and unused address
    pin = 3'b000;
    step(4);
    rd(2'd1, "R9 all three set", 8'h07);
    rd(2'd3, "R9 unused address", 8'h00);
    clear_all();
    rd(2'd1, "R6 all cleared", 8'h00);

    // Pseudo-random phase checked against the model
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) pin = lfsr[3:1];
      if (lfsr[15:12] == 4'h0) dir = lfsr[6:4];
      if (lfsr[15:12] == 4'h1) en = ~lfsr[9:7];
      addr = lfsr[11:10];
      stb = (lfsr[5:4] == 2'b11);
      step(1);
    end
    stb = 1'b0;
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule